// File: doc/BRIEF.md
# Modem Line Loop-back and Status Unit

This block handles the modem-control and modem-status side of one serial channel. It takes the host's modem-control bits and a diagnostic loop-back enable. It also takes the four external modem input lines, the receive pin and the serial stream from the transmitter. It drives the transmit pin, the four modem output pins and the serial line that feeds the receiver. It also produces an 8-bit modem status value and a modem-status interrupt request.

In normal operation the modem inputs pass through a synchronizer into the status value, and the serial lines pass straight through. In loop-back mode the transmitter output is turned back into the receiver, and the external pins are cut off. The modem-control bits then stand in for the four modem inputs. Change detection and the interrupt keep working on whichever sources are selected, so the host can test the whole status path without external wiring. All lines are treated as logical levels, with 1 meaning asserted.

Top module: `modem_loop_unit`

## Requirements
- R1: With `loopEn`=1, `pinTx` is 1 and `rxSerial` equals `txSerial`. With `loopEn`=0, `pinTx` equals `txSerial` and `rxSerial` equals `pinRx`. These paths have no register.
- R2: With `loopEn`=0, `pinDtr`, `pinRts`, `pinOut1` and `pinOut2` follow `ctlDtr`, `ctlRts`, `ctlOut1` and `ctlOut2`. With `loopEn`=1, all four output pins are 0.
- R3: With `loopEn`=1, the effective sources are mapped as follows: CTS from `ctlRts`, DSR from `ctlDtr`, RI from `ctlOut1`, CD from `ctlOut2`. Each appears in `statusReg` one clock edge after it is sampled, and `pinCts`, `pinDsr`, `pinRi` and `pinCd` have no effect.
- R4: With `loopEn`=0, the external modem pins pass through a SYNC_STAGES-deep synchronizer (default 2). A pin level sampled at edge k appears in `statusReg` after edge k+SYNC_STAGES. The field layout is bit 7 CD, bit 6 RI, bit 5 DSR, bit 4 CTS.
- R5: Change flags for CTS (bit 0), DSR (bit 1) and CD (bit 3) are set at the same edge that any change of the matching effective line reaches the upper nibble.
- R6: The RI flag (bit 2) is set only when the effective RI goes from 1 to 0. A rising RI leaves it unchanged.
- R7: `statusRead` high at a clock edge clears all four change flags at that edge. A change detected at that same edge still sets its flag.
- R8: `msIrq` is 1 exactly when `msIntEn` is 1 and at least one change flag is set.
- R9: After reset, the change flags are 0, the upper nibble is 0 and `msIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlDtr | input | 1 | Host DTR control bit |
| ctlRts | input | 1 | Host RTS control bit |
| ctlOut1 | input | 1 | Host general output 1 |
| ctlOut2 | input | 1 | Host general output 2 |
| loopEn | input | 1 | Diagnostic loop-back enable |
| msIntEn | input | 1 | Modem-status interrupt enable |
| statusRead | input | 1 | One-cycle strobe marking a host read of the status value |
| txSerial | input | 1 | Serial output of the transmitter |
| pinRx | input | 1 | External receive pin |
| pinCts | input | 1 | External CTS pin |
| pinDsr | input | 1 | External DSR pin |
| pinRi | input | 1 | External RI pin |
| pinCd | input | 1 | External CD pin |
| pinTx | output | 1 | External transmit pin |
| pinDtr | output | 1 | External DTR pin |
| pinRts | output | 1 | External RTS pin |
| pinOut1 | output | 1 | External general output 1 |
| pinOut2 | output | 1 | External general output 2 |
| rxSerial | output | 1 | Serial line feeding the receiver |
| statusReg | output | 8 | Modem status: line states high, change flags low |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
A stale line state shows in the upper nibble of `statusReg` within one edge of the expected latency. A lost change event shows as a missing flag and a silent `msIrq` on the very next cycle. The bench steps a behavioural model every clock and compares every output every cycle, so any divergence is reported in the cycle it appears. The stimulus includes reads that collide with changes, RI edges in both directions, and mode switches while the external pins are toggling.

// File: rtl/modem_loop_pkg.sv
package modem_loop_pkg;
  typedef struct packed {
    logic cd;
    logic ri;
    logic dsr;
    logic cts;
  } modemLines_t;

  typedef struct packed {
    modemLines_t effLines;
    logic        clearDeltas;
  } ctrlStrobes_t;
endpackage

// File: rtl/modem_route_ctrl.sv
module modem_route_ctrl
  import modem_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlDtr,
  input  logic         ctlRts,
  input  logic         ctlOut1,
  input  logic         ctlOut2,
  input  logic         loopEn,
  input  logic         statusRead,
  input  logic         txSerial,
  input  logic         pinRx,
  input  modemLines_t  pinLines,
  output logic         pinTx,
  output logic         pinDtr,
  output logic         pinRts,
  output logic         pinOut1,
  output logic         pinOut2,
  output logic         rxSerial,
  output ctrlStrobes_t strobes
);
  localparam int LINE_W = $bits(modemLines_t);
  localparam int SYNC_W = SYNC_STAGES * LINE_W;

  logic [SYNC_W-1:0] syncPipe;
  modemLines_t       syncedLines;
  modemLines_t       loopLines;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= pinLines;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= {syncPipe[SYNC_W-LINE_W-1:0], pinLines};
      end
    end
  endgenerate

  assign syncedLines = modemLines_t'(syncPipe[SYNC_W-1 -: LINE_W]);

  always_comb begin
    loopLines.cd  = ctlOut2;
    loopLines.ri  = ctlOut1;
    loopLines.dsr = ctlDtr;
    loopLines.cts = ctlRts;
  end

  always_comb begin
    strobes.effLines    = loopEn ? loopLines : syncedLines;
    strobes.clearDeltas = statusRead;
    pinTx    = loopEn ? 1'b1 : txSerial;
    rxSerial = loopEn ? txSerial : pinRx;
    pinDtr   = ctlDtr  & ~loopEn;
    pinRts   = ctlRts  & ~loopEn;
    pinOut1  = ctlOut1 & ~loopEn;
    pinOut2  = ctlOut2 & ~loopEn;
  end

  // R4: a stable pin level reaches the effective lines after the chain
  assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEn && $past(!loopEn) && $stable(pinLines) && $past($stable(pinLines)))
      |-> (strobes.effLines == pinLines));
endmodule

// File: rtl/modem_status_dp.sv
module modem_status_dp
  import modem_loop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         msIntEn,
  output logic [7:0]   statusReg,
  output logic         msIrq
);
  modemLines_t curState;
  logic [3:0]  deltaFlags;
  logic [3:0]  setMask;
  logic [3:0]  deltaNext;

  always_comb begin
    setMask[0] = strobes.effLines.cts != curState.cts;
    setMask[1] = strobes.effLines.dsr != curState.dsr;
    setMask[2] = curState.ri & ~strobes.effLines.ri;
    setMask[3] = strobes.effLines.cd  != curState.cd;
    deltaNext  = (strobes.clearDeltas ? 4'b0000 : deltaFlags) | setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= '0;
      deltaFlags <= '0;
    end else begin
      curState   <= strobes.effLines;
      deltaFlags <= deltaNext;
    end
  end

  assign statusReg = {curState, deltaFlags};
  assign msIrq     = msIntEn & (|deltaFlags);

  assert_state_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (curState == $past(strobes.effLines)));

  assert_cts_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.effLines.cts != statusReg[4]) |=> statusReg[0]);

  assert_ri_rise_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.effLines.ri && !statusReg[6] && !statusReg[2] && !strobes.clearDeltas) |=> !statusReg[2]);

  assert_ri_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.effLines.ri && statusReg[6]) |=> statusReg[2]);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearDeltas && strobes.effLines == curState) |=> (statusReg[3:0] == 4'b0000));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msIrq) |-> (msIntEn && statusReg[3:0] != 4'b0000));
endmodule

// File: rtl/modem_loop_unit.sv
module modem_loop_unit
  import modem_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlDtr,
  input  logic       ctlRts,
  input  logic       ctlOut1,
  input  logic       ctlOut2,
  input  logic       loopEn,
  input  logic       msIntEn,
  input  logic       statusRead,
  input  logic       txSerial,
  input  logic       pinRx,
  input  logic       pinCts,
  input  logic       pinDsr,
  input  logic       pinRi,
  input  logic       pinCd,
  output logic       pinTx,
  output logic       pinDtr,
  output logic       pinRts,
  output logic       pinOut1,
  output logic       pinOut2,
  output logic       rxSerial,
  output logic [7:0] statusReg,
  output logic       msIrq
);
  ctrlStrobes_t strobes;
  modemLines_t  pinLines;

  assign pinLines = '{cd: pinCd, ri: pinRi, dsr: pinDsr, cts: pinCts};

  modem_route_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctlDtr(ctlDtr), .ctlRts(ctlRts), .ctlOut1(ctlOut1), .ctlOut2(ctlOut2),
    .loopEn(loopEn), .statusRead(statusRead), .txSerial(txSerial),
    .pinRx(pinRx), .pinLines(pinLines),
    .pinTx(pinTx), .pinDtr(pinDtr), .pinRts(pinRts),
    .pinOut1(pinOut1), .pinOut2(pinOut2), .rxSerial(rxSerial),
    .strobes(strobes)
  );

  modem_status_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .msIntEn(msIntEn),
    .statusReg(statusReg), .msIrq(msIrq)
  );

  // R3: in loop-back the control bits land in the upper nibble one edge later
  assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> (statusReg[7:4] == $past({ctlOut2, ctlOut1, ctlDtr, ctlRts})));

  // R2: modem output pins stay low for as long as loop-back is held
  assert_loop_outputs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && $past(loopEn)) |-> !(pinDtr || pinRts || pinOut1 || pinOut2));
endmodule

// File: tb/modem_loop_unit_tb_top.sv
module modem_loop_unit_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlDtr = 0, ctlRts = 0, ctlOut1 = 0, ctlOut2 = 0;
  logic loopEn = 0, msIntEn = 0, statusRead = 0, txSerial = 1, pinRx = 1;
  logic pinCts = 0, pinDsr = 0, pinRi = 0, pinCd = 0;
  logic pinTx, pinDtr, pinRts, pinOut1, pinOut2, rxSerial, msIrq;
  logic [7:0] statusReg;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  modem_loop_unit #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .ctlDtr(ctlDtr), .ctlRts(ctlRts),
    .ctlOut1(ctlOut1), .ctlOut2(ctlOut2), .loopEn(loopEn), .msIntEn(msIntEn),
    .statusRead(statusRead), .txSerial(txSerial), .pinRx(pinRx),
    .pinCts(pinCts), .pinDsr(pinDsr), .pinRi(pinRi), .pinCd(pinCd),
    .pinTx(pinTx), .pinDtr(pinDtr), .pinRts(pinRts), .pinOut1(pinOut1),
    .pinOut2(pinOut2), .rxSerial(rxSerial), .statusReg(statusReg), .msIrq(msIrq)
  );

  // Behavioural reference: pin history queue, line state and sticky flags
  bit [3:0] pinHist[$];
  bit [3:0] mState = 0;
  bit [3:0] mFlags = 0;

  initial for (int i = 0; i < SYNC; i++) pinHist.push_back(4'h0);

  always @(posedge clk) begin
    bit [3:0] eff;
    bit [3:0] pinNow;
    bit [3:0] setF;
    pinNow = {pinCd, pinRi, pinDsr, pinCts};
    if (!rstN) begin
      mState = 0;
      mFlags = 0;
      pinHist.delete();
      for (int i = 0; i < SYNC; i++) pinHist.push_back(4'h0);
    end else begin
      eff = loopEn ? {ctlOut2, ctlOut1, ctlDtr, ctlRts} : pinHist[0];
      setF = 0;
      setF[0] = eff[0] != mState[0];
      setF[1] = eff[1] != mState[1];
      setF[3] = eff[3] != mState[3];
      setF[2] = mState[2] && !eff[2];
      mFlags = (statusRead ? 4'h0 : mFlags) | setF;
      mState = eff;
      void'(pinHist.pop_front());
      pinHist.push_back(pinNow);
    end
  end

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic checkByte(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference, at the falling edge
  task automatic compareAll();
    checkBit("R1 pinTx", pinTx, loopEn ? 1'b1 : txSerial);
    checkBit("R1 rxSerial", rxSerial, loopEn ? txSerial : pinRx);
    checkBit("R2 pinDtr", pinDtr, loopEn ? 1'b0 : ctlDtr);
    checkBit("R2 pinRts", pinRts, loopEn ? 1'b0 : ctlRts);
    checkBit("R2 pinOut1", pinOut1, loopEn ? 1'b0 : ctlOut1);
    checkBit("R2 pinOut2", pinOut2, loopEn ? 1'b0 : ctlOut2);
    checkByte("R3/R4/R5/R6/R7 statusReg", statusReg, {mState, mFlags});
    checkBit("R8 msIrq", msIrq, msIntEn && (mFlags != 0));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      statusRead = 0;
    end
  endtask

  task automatic doRead();
    statusRead = 1;
    step(1);
  endtask

  initial begin
    bit done;
    done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        checkByte("R9 reset status", statusReg, 8'h00);
        checkBit("R9 reset irq", msIrq, 1'b0);
        msIntEn = 1;
        // R4/R5: CTS rises, visible after SYNC+1 edges, flag sets
        pinCts = 1; step(1);
        checkBit("R4 early CTS not yet visible", statusReg[4], 1'b0);
        step(SYNC);
        checkBit("R4 CTS visible", statusReg[4], 1'b1);
        checkBit("R5 dCTS set", statusReg[0], 1'b1);
        checkBit("R8 irq with flag", msIrq, 1'b1);
        doRead();
        checkByte("R7 flags cleared by read", statusReg, 8'h10);
        // R6: RI rising does not set the trailing-edge flag; falling does
        pinRi = 1; step(SYNC + 2);
        checkBit("R6 RI rise no flag", statusReg[2], 1'b0);
        pinRi = 0; step(SYNC + 2);
        checkBit("R6 RI fall flag", statusReg[2], 1'b1);
        doRead();
        // R7: read colliding with a change keeps the new flag
        pinDsr = 1; step(SYNC);
        doRead();
        checkBit("R7 collision keeps dDSR", statusReg[1], 1'b1);
        msIntEn = 0; step(2);
        checkBit("R8 irq gated off", msIrq, 1'b0);
        msIntEn = 1; doRead();
        // R1/R2/R3: loop-back with external pin noise
        loopEn = 1; ctlRts = 1; ctlOut2 = 1; txSerial = 0; pinRx = 1;
        step(1);
        checkBit("R1 rx from tx in loop", rxSerial, 1'b0);
        checkBit("R1 tx pin idle in loop", pinTx, 1'b1);
        checkBit("R3 CTS from RTS", statusReg[4], 1'b1);
        checkBit("R3 CD from OUT2", statusReg[7], 1'b1);
        doRead();
        pinCts = 0; pinDsr = 0; pinCd = 1; pinRi = 1; step(SYNC + 3);
        checkByte("R3 external pins ignored", statusReg, 8'h90);
        ctlOut1 = 1; step(1); ctlOut1 = 0; step(1);
        checkBit("R3/R6 RI from OUT1 falling", statusReg[2], 1'b1);
        loopEn = 0; step(SYNC + 2);
        // Random phase
        for (int k = 0; k < 3000; k++) begin
          int r;
          r = $urandom_range(0, 99);
          if (r < 6)  pinCts = ~pinCts;
          else if (r < 11) pinDsr = ~pinDsr;
          else if (r < 16) pinRi = ~pinRi;
          else if (r < 21) pinCd = ~pinCd;
          else if (r < 25) {ctlOut2, ctlOut1, ctlDtr, ctlRts} = 4'($urandom);
          else if (r < 27) loopEn = ~loopEn;
          else if (r < 29) msIntEn = ~msIntEn;
          if ($urandom_range(0, 9) == 0) statusRead = 1;
          txSerial = 1'($urandom); pinRx = 1'($urandom);
          @(negedge clk); compareAll(); statusRead = 0;
        end
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule